// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Control

This block is the hazard controller of a five-stage integer pipeline (fetch, decode, execute, memory, write-back) in which conditional branches are resolved in the decode stage. It looks at the register indices and the write and load flags that travel with each in-flight instruction. From them it picks the operand source for the execute-stage ALU and for the decode-stage branch comparator, and it decides when the front of the pipeline must wait.

A read-after-write between ALU instructions is covered by forwarding alone. A load followed at once by a reader costs one wait cycle. Because the branch comparator sits in decode, a branch has to wait for an ALU result that is still in execute. It also has to wait for a load that is still in execute or in memory, so it can lose up to two cycles behind a load. While the pipeline waits, the PC and the fetch/decode register are held and a bubble goes into decode/execute. When a branch that is not waiting is taken, the one instruction fetched behind it is flushed.

The block is purely combinational and sits beside the datapath, which is outside its scope. Each stage's destination index comes from that stage's own pipeline register. The write-back stage therefore always names the register of the instruction that is retiring.

Top module: `hazard_fwd_ctrl`

## Requirements
- R1: An execute-stage operand whose index equals the memory stage's destination, with the memory-stage write enable high, gets forward code 2'b10 (take the EX/MEM result). Code 2'b00 means the register file value and code 2'b01 means the MEM/WB value.
- R2: An execute-stage operand that matches only the write-back stage's destination, with that stage's write enable high, gets code 2'b01. When both the memory and write-back stages match, code 2'b10 wins.
- R3: Register index 0, or any stage whose write enable is low, never produces a forward code other than 2'b00 and never causes a wait.
- R4: An ALU (non-load) producer in execute followed by a non-branch reader in decode causes no wait.
- R5: A load in execute whose destination matches either decode source raises PC hold, fetch/decode hold and execute bubble together for that cycle.
- R6: A branch in decode whose source matches the destination of any writing instruction in execute waits one cycle. The wait is signalled by the same three hold/bubble outputs.
- R7: A branch in decode whose source matches a load in the memory stage also waits. A branch directly behind a load therefore waits two cycles in total. In the third cycle, with the load in write-back, it proceeds with decode forward code 2'b01.
- R8: A decode-stage branch source gets code 2'b10 from a non-load writer in memory and 2'b01 from a writer in write-back. The 2'b10 choice has priority. When the branch request is low, both decode codes are 2'b00.
- R9: The fetch/decode flush is high exactly when a branch is requested, its comparison reports taken, and no wait is raised in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1_i | input | 5 | First source index of the decode-stage instruction |
| id_rs2_i | input | 5 | Second source index of the decode-stage instruction |
| id_branch_i | input | 1 | Decode-stage instruction is a conditional branch needing comparison |
| id_taken_i | input | 1 | Branch comparator reports taken |
| ex_rs1_i | input | 5 | First source index of the execute-stage instruction |
| ex_rs2_i | input | 5 | Second source index of the execute-stage instruction |
| ex_rd_i | input | 5 | Destination index in execute |
| ex_we_i | input | 1 | Execute-stage instruction writes a register |
| ex_load_i | input | 1 | Execute-stage instruction is a load |
| mem_rd_i | input | 5 | Destination index in memory stage |
| mem_we_i | input | 1 | Memory-stage instruction writes a register |
| mem_load_i | input | 1 | Memory-stage instruction is a load |
| wb_rd_i | input | 5 | Destination index in write-back |
| wb_we_i | input | 1 | Write-back instruction writes a register |
| ex_fwd_a_o | output | 2 | Source code for ALU operand A |
| ex_fwd_b_o | output | 2 | Source code for ALU operand B |
| id_fwd_a_o | output | 2 | Source code for comparator operand A |
| id_fwd_b_o | output | 2 | Source code for comparator operand B |
| pc_hold_o | output | 1 | Keep the PC unchanged this cycle |
| ifid_hold_o | output | 1 | Keep the fetch/decode register unchanged |
| idex_bubble_o | output | 1 | Insert a no-op into decode/execute |
| ifid_flush_o | output | 1 | Discard the fetched instruction behind a taken branch |

## Verification
Forwarding is tried with a match in memory only, in write-back only and in both. This separates the priority order from a plain index match, and it is done for each operand so that a swapped operand is caught. Index zero and cleared write enables are presented with otherwise matching indices, to show that the match alone does not trigger anything. Wait behaviour is exercised with the same index pair under four producer kinds: ALU or load, each in front of a non-branch or a branch reader. These show that only the load-use case and the branch cases hold the front end. A load followed by a branch is stepped through three cycles to confirm two waits and then forwarding from write-back. The flush output is driven with taken and not-taken results, with and without a simultaneous wait.

// File: rtl/hz_pkg.sv
package hz_pkg;

    localparam int RIDX_W = 5;
    localparam int NSRC   = 2;

    typedef logic [RIDX_W-1:0] ridx_t;

    typedef enum logic [1:0] {
        SRC_RF    = 2'b00,
        SRC_MEMWB = 2'b01,
        SRC_EXMEM = 2'b10
    } src_sel_e;

    typedef struct packed {
        ridx_t rd;
        logic  we;
        logic  load;
    } wr_tag_t;

    function automatic logic tag_hits(input wr_tag_t tag, input ridx_t src);
        return tag.we && (tag.rd != '0) && (tag.rd == src);
    endfunction

endpackage

// File: rtl/hz_src_select.sv
module hz_src_select
    import hz_pkg::*;
#(
    parameter bit SKIP_MEM_LOAD = 1'b0
) (
    input  logic     enable_i,
    input  ridx_t    src_i,
    input  wr_tag_t  mem_i,
    input  wr_tag_t  wb_i,
    output src_sel_e sel_o
);

    logic mem_ok;
    logic wb_ok;

    always_comb begin
        mem_ok = tag_hits(mem_i, src_i);
        if (SKIP_MEM_LOAD && mem_i.load) begin
            mem_ok = 1'b0;
        end
        wb_ok = tag_hits(wb_i, src_i);
    end

    always_comb begin
        if (!enable_i) begin
            sel_o = SRC_RF;
        end else if (mem_ok) begin
            sel_o = SRC_EXMEM;
        end else if (wb_ok) begin
            sel_o = SRC_MEMWB;
        end else begin
            sel_o = SRC_RF;
        end
    end

    always_comb begin
        if (src_i == '0) begin
            AST_ZERO_REG_NOT_FORWARDED: assert (sel_o == SRC_RF); // R3
        end
        if (!mem_i.we && !wb_i.we) begin
            AST_NO_WRITER_NO_FORWARD: assert (sel_o == SRC_RF); // R3
        end
    end

endmodule

// File: rtl/hz_wait_detect.sv
module hz_wait_detect
    import hz_pkg::*;
(
    input  ridx_t   id_src_i [NSRC],
    input  logic    id_branch_i,
    input  wr_tag_t ex_i,
    input  wr_tag_t mem_i,
    output logic    load_use_o,
    output logic    br_on_ex_o,
    output logic    br_on_load_o
);

    always_comb begin
        load_use_o   = 1'b0;
        br_on_ex_o   = 1'b0;
        br_on_load_o = 1'b0;
        for (int s = 0; s < NSRC; s++) begin
            if (ex_i.load && tag_hits(ex_i, id_src_i[s])) begin
                load_use_o = 1'b1;
            end
            if (id_branch_i && tag_hits(ex_i, id_src_i[s])) begin
                br_on_ex_o = 1'b1;
            end
            if (id_branch_i && mem_i.load && tag_hits(mem_i, id_src_i[s])) begin
                br_on_load_o = 1'b1;
            end
        end
    end

    always_comb begin
        if (!ex_i.we) begin
            AST_EX_SILENT_NO_EX_WAIT: assert (!load_use_o && !br_on_ex_o); // R3
        end
        if (!id_branch_i) begin
            AST_NONBRANCH_NO_BR_WAIT: assert (!br_on_ex_o && !br_on_load_o); // R6
        end
    end

endmodule

// File: rtl/hazard_fwd_ctrl.sv
module hazard_fwd_ctrl
    import hz_pkg::*;
(
    input  logic [4:0] id_rs1_i,
    input  logic [4:0] id_rs2_i,
    input  logic       id_branch_i,
    input  logic       id_taken_i,
    input  logic [4:0] ex_rs1_i,
    input  logic [4:0] ex_rs2_i,
    input  logic [4:0] ex_rd_i,
    input  logic       ex_we_i,
    input  logic       ex_load_i,
    input  logic [4:0] mem_rd_i,
    input  logic       mem_we_i,
    input  logic       mem_load_i,
    input  logic [4:0] wb_rd_i,
    input  logic       wb_we_i,
    output logic [1:0] ex_fwd_a_o,
    output logic [1:0] ex_fwd_b_o,
    output logic [1:0] id_fwd_a_o,
    output logic [1:0] id_fwd_b_o,
    output logic       pc_hold_o,
    output logic       ifid_hold_o,
    output logic       idex_bubble_o,
    output logic       ifid_flush_o
);

    wr_tag_t  ex_tag;
    wr_tag_t  mem_tag;
    wr_tag_t  wb_tag;
    ridx_t    ex_src [NSRC];
    ridx_t    id_src [NSRC];
    src_sel_e ex_sel [NSRC];
    src_sel_e id_sel [NSRC];
    logic     load_use;
    logic     br_on_ex;
    logic     br_on_load;
    logic     wait_any;

    always_comb begin
        ex_tag    = '{rd: ex_rd_i,  we: ex_we_i,  load: ex_load_i};
        mem_tag   = '{rd: mem_rd_i, we: mem_we_i, load: mem_load_i};
        wb_tag    = '{rd: wb_rd_i,  we: wb_we_i,  load: 1'b0};
        ex_src[0] = ex_rs1_i;
        ex_src[1] = ex_rs2_i;
        id_src[0] = id_rs1_i;
        id_src[1] = id_rs2_i;
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        hz_src_select #(.SKIP_MEM_LOAD(1'b0)) u_ex_sel (
            .enable_i (1'b1),
            .src_i    (ex_src[g]),
            .mem_i    (mem_tag),
            .wb_i     (wb_tag),
            .sel_o    (ex_sel[g])
        );
        hz_src_select #(.SKIP_MEM_LOAD(1'b1)) u_id_sel (
            .enable_i (id_branch_i),
            .src_i    (id_src[g]),
            .mem_i    (mem_tag),
            .wb_i     (wb_tag),
            .sel_o    (id_sel[g])
        );
    end

    hz_wait_detect u_wait (
        .id_src_i     (id_src),
        .id_branch_i  (id_branch_i),
        .ex_i         (ex_tag),
        .mem_i        (mem_tag),
        .load_use_o   (load_use),
        .br_on_ex_o   (br_on_ex),
        .br_on_load_o (br_on_load)
    );

    always_comb begin
        wait_any      = load_use || br_on_ex || br_on_load;
        pc_hold_o     = wait_any;
        ifid_hold_o   = wait_any;
        idex_bubble_o = wait_any;
        ifid_flush_o  = id_branch_i && id_taken_i && !wait_any;
        ex_fwd_a_o    = ex_sel[0];
        ex_fwd_b_o    = ex_sel[1];
        id_fwd_a_o    = id_sel[0];
        id_fwd_b_o    = id_sel[1];
    end

    always_comb begin
        AST_FLUSH_NEVER_WITH_BUBBLE: assert (!(ifid_flush_o && idex_bubble_o)); // R9
        AST_HOLDS_MOVE_TOGETHER: assert ((pc_hold_o == ifid_hold_o) && (ifid_hold_o == idex_bubble_o)); // R5
        if (!id_branch_i && !ex_load_i) begin
            AST_ALU_RAW_NO_WAIT: assert (!pc_hold_o); // R4
        end
        if (!id_branch_i) begin
            AST_ID_FWD_IDLE: assert ((id_fwd_a_o == 2'b00) && (id_fwd_b_o == 2'b00)); // R8
        end
        if (ex_fwd_a_o == 2'b10) begin
            AST_EXMEM_A_NEEDS_MEM_MATCH: assert (mem_we_i && (mem_rd_i == ex_rs1_i)); // R1
        end
        if (ex_fwd_b_o == 2'b01) begin
            AST_MEMWB_B_NEEDS_WB_MATCH: assert (wb_we_i && (wb_rd_i == ex_rs2_i)); // R2
        end
    end

endmodule

// File: tb/hazard_fwd_ctrl_tb.sv
module hazard_fwd_ctrl_tb_top;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [4:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
    logic       id_branch, id_taken, ex_we, ex_load, mem_we, mem_load, wb_we;
    logic [1:0] ex_fwd_a, ex_fwd_b, id_fwd_a, id_fwd_b;
    logic       pc_hold, ifid_hold, idex_bubble, ifid_flush;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    hazard_fwd_ctrl dut_i (
        .id_rs1_i (id_rs1), .id_rs2_i (id_rs2),
        .id_branch_i (id_branch), .id_taken_i (id_taken),
        .ex_rs1_i (ex_rs1), .ex_rs2_i (ex_rs2), .ex_rd_i (ex_rd),
        .ex_we_i (ex_we), .ex_load_i (ex_load),
        .mem_rd_i (mem_rd), .mem_we_i (mem_we), .mem_load_i (mem_load),
        .wb_rd_i (wb_rd), .wb_we_i (wb_we),
        .ex_fwd_a_o (ex_fwd_a), .ex_fwd_b_o (ex_fwd_b),
        .id_fwd_a_o (id_fwd_a), .id_fwd_b_o (id_fwd_b),
        .pc_hold_o (pc_hold), .ifid_hold_o (ifid_hold),
        .idex_bubble_o (idex_bubble), .ifid_flush_o (ifid_flush)
    );

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        id_rs1 = 0; id_rs2 = 0; id_branch = 0; id_taken = 0;
        ex_rs1 = 0; ex_rs2 = 0; ex_rd = 0; ex_we = 0; ex_load = 0;
        mem_rd = 0; mem_we = 0; mem_load = 0; wb_rd = 0; wb_we = 0;
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    function automatic logic [3:0] holds();
        return {1'b0, pc_hold, ifid_hold, idex_bubble};
    endfunction

    task automatic t_idle_r3();
        idle(); settle();
        chk("R3 idle ex fwd", {ex_fwd_a, ex_fwd_b}, 4'h0);
        chk("R3 idle id fwd", {id_fwd_a, id_fwd_b}, 4'h0);
        chk("R3 idle holds", holds(), 4'h0);
        chk("R9 idle flush", {3'b0, ifid_flush}, 4'h0);
    endtask

    task automatic t_exmem_r1();
        idle(); mem_rd = 5; mem_we = 1; ex_rs1 = 5; ex_rs2 = 6; settle();
        chk("R1 operand A from EX/MEM", {ex_fwd_a, ex_fwd_b}, 4'b1000);
        ex_rs1 = 6; ex_rs2 = 5; settle();
        chk("R1 operand B from EX/MEM", {ex_fwd_a, ex_fwd_b}, 4'b0010);
    endtask

    task automatic t_memwb_r2();
        idle(); wb_rd = 7; wb_we = 1; ex_rs2 = 7; ex_rs1 = 3; settle();
        chk("R2 operand B from MEM/WB", {ex_fwd_a, ex_fwd_b}, 4'b0001);
        mem_rd = 7; mem_we = 1; settle();
        chk("R2 EX/MEM priority", {ex_fwd_a, ex_fwd_b}, 4'b0010);
        ex_rs1 = 7; ex_rs2 = 0; mem_rd = 4; settle();
        chk("R2 operand A from MEM/WB", {ex_fwd_a, ex_fwd_b}, 4'b0100);
    endtask

    task automatic t_zero_r3();
        idle(); mem_rd = 0; mem_we = 1; wb_rd = 0; wb_we = 1; ex_rs1 = 0; ex_rs2 = 0; settle();
        chk("R3 x0 never forwarded", {ex_fwd_a, ex_fwd_b}, 4'h0);
        idle(); mem_rd = 4; mem_we = 0; wb_rd = 4; wb_we = 0; ex_rs1 = 4; ex_rs2 = 4; settle();
        chk("R3 write enable low no forward", {ex_fwd_a, ex_fwd_b}, 4'h0);
        idle(); ex_load = 1; ex_we = 1; ex_rd = 0; id_rs1 = 0; settle();
        chk("R3 load to x0 no wait", holds(), 4'h0);
        idle(); ex_load = 1; ex_we = 0; ex_rd = 9; id_rs1 = 9; settle();
        chk("R3 load with we low no wait", holds(), 4'h0);
    endtask

    task automatic t_alu_raw_r4();
        idle(); ex_we = 1; ex_rd = 3; id_rs1 = 3; id_rs2 = 3; settle();
        chk("R4 ALU RAW no wait", holds(), 4'h0);
    endtask

    task automatic t_load_use_r5();
        idle(); ex_we = 1; ex_load = 1; ex_rd = 9; id_rs2 = 9; id_rs1 = 2; settle();
        chk("R5 load-use waits", holds(), 4'h7);
        id_rs2 = 8; settle();
        chk("R5 unrelated after load no wait", holds(), 4'h0);
    endtask

    task automatic t_branch_ex_r6();
        idle(); id_branch = 1; ex_we = 1; ex_rd = 6; id_rs1 = 6; id_rs2 = 1; settle();
        chk("R6 branch on EX result waits", holds(), 4'h7);
        id_taken = 1; settle();
        chk("R9 no flush during wait", {3'b0, ifid_flush}, 4'h0);
    endtask

    task automatic t_branch_load_r7();
        int waits = 0;
        idle(); id_branch = 1; id_rs2 = 12; id_rs1 = 1;
        ex_we = 1; ex_load = 1; ex_rd = 12; settle();
        chk("R7 cycle1 load in EX waits", holds(), 4'h7);
        if (pc_hold) waits++;
        idle(); id_branch = 1; id_rs2 = 12; id_rs1 = 1;
        mem_we = 1; mem_load = 1; mem_rd = 12; settle();
        chk("R7 cycle2 load in MEM waits", holds(), 4'h7);
        chk("R7 no EX/MEM fwd of load", {2'b0, id_fwd_b}, 4'h0);
        if (pc_hold) waits++;
        idle(); id_branch = 1; id_rs2 = 12; id_rs1 = 1;
        wb_we = 1; wb_rd = 12; settle();
        chk("R7 cycle3 proceeds", holds(), 4'h0);
        chk("R7 cycle3 decode fwd MEM/WB", {id_fwd_a, id_fwd_b}, 4'b0001);
        chk("R7 total waits two", waits[3:0], 4'd2);
    endtask

    task automatic t_branch_fwd_r8();
        idle(); id_branch = 1; mem_we = 1; mem_rd = 8; id_rs2 = 8; id_rs1 = 2; settle();
        chk("R8 comparator B from EX/MEM", {id_fwd_a, id_fwd_b}, 4'b0010);
        chk("R8 no wait on MEM ALU", holds(), 4'h0);
        wb_we = 1; wb_rd = 2; settle();
        chk("R8 comparator A from MEM/WB", {id_fwd_a, id_fwd_b}, 4'b0110);
        wb_rd = 8; id_rs1 = 8; settle();
        chk("R8 EX/MEM priority in decode", {id_fwd_a, id_fwd_b}, 4'b1010);
        id_branch = 0; settle();
        chk("R8 no branch no decode fwd", {id_fwd_a, id_fwd_b}, 4'h0);
    endtask

    task automatic t_flush_r9();
        idle(); id_branch = 1; id_taken = 1; id_rs1 = 3; id_rs2 = 4; settle();
        chk("R9 taken flushes", {3'b0, ifid_flush}, 4'h1);
        id_taken = 0; settle();
        chk("R9 not taken no flush", {3'b0, ifid_flush}, 4'h0);
        id_branch = 0; id_taken = 1; settle();
        chk("R9 no branch no flush", {3'b0, ifid_flush}, 4'h0);
    endtask

    initial begin
        idle();
        t_idle_r3();
        t_exmem_r1();
        t_memwb_r2();
        t_zero_r3();
        t_alu_raw_r4();
        t_load_use_r5();
        t_branch_ex_r6();
        t_branch_load_r7();
        t_branch_fwd_r8();
        t_flush_r9();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule